// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM. Its address and control port is registered, and its write data arrives late. Every rising clock edge can accept a new read, write or deselect command, so the block never needs an idle cycle when it turns from reads to writes or back.

A read latches its address at the command edge and loads the selected word into the output register at the following edge. A write latches its address at the command edge and takes its data from the input bus two enabled edges later. During the edge in between, the data bus is turned off so that the host can drive the write data. The bidirectional 36-bit bus is modelled as a separate input, output and drive-enable. The word is split into four lanes of nine bits, and each lane has its own active-low write select.

An active-low clock enable stops the whole pipeline. Three chip enables together with an active-low load strobe qualify the start of a command. A read that overlaps a write still in flight receives the merged new data, never stale array contents. Burst address stepping is left to an external sequencer. The depth is 2**AW words: AW of 17 gives the full 128K-word part, and the default is smaller so that simulation stays small.

Top module: `pipe_sram`

## Requirements
- R1: While rst is high at a clock edge, every pipeline valid flag is cleared, so dq_oe is low after that edge until a read completes.
- R2: A read command latches addr at edge k. After edge k+1, dq_out holds the stored word and dq_oe equals the inverse of oe_n.
- R3: While oe_n is high, dq_oe is low at once, without waiting for a clock edge.
- R4: A deselect at edge k does not disturb the output of an earlier read until edge k+1. After edge k+1, dq_oe is low.
- R5: A write command at edge k forces dq_oe low after edge k+1, whatever oe_n is. The write data is taken from dq_in at edge k+2.
- R6: Lane i is bits [9i+8:9i] of the word. A write stores lane i only when bw_n[i] is 0. Lanes whose bw_n bit is 1 keep their contents.
- R7: A read that starts one edge after a write to the same address returns the new write data merged lane by lane with the old word. A read that starts two edges after such a write returns the same merged word.
- R8: An edge with clk_en_n high is ignored. Commands, write data and the output register stay unchanged, and that edge does not count toward any pipeline latency.
- R9: A command starts only when cs1_n is low, cs2 is high and cs3_n is low. With any one of them wrong, the edge acts as a deselect and no write takes place.
- R10: An edge with adv_ld_n high starts no command and acts as a deselect.
- R11: Reads, writes and deselects can be issued on consecutive edges in any order, and each read returns the correct data with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline valid flags |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| cs1_n | input | 1 | Chip enable one, active low |
| cs2 | input | 1 | Chip enable two, active high |
| cs3_n | input | 1 | Chip enable three, active low |
| adv_ld_n | input | 1 | Active-low load strobe that starts a command |
| wr_n | input | 1 | Low selects write, high selects read |
| bw_n | input | LANES | Active-low write select for each lane |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | LANES*LANE_W | Write data seen on the bus |
| dq_out | output | LANES*LANE_W | Read data from the output stage |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The bound checker watches the drive-enable timing on every cycle. It checks that dq_oe is off after reset, when oe_n is high, one edge after a deselect or a write turnaround, and that it follows oe_n one edge after a read. It also checks that dq_out stays frozen across ignored edges. These checks cover only the bus direction and stalls. Which word appears needs the directed scenarios: lane merging, forwarding from a write in flight, writes blocked by each chip enable or by the load strobe, and the alternating read/write stream all depend on data values that only the bench predicts.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  localparam int DEF_AW     = 10;
  localparam int DEF_LANES  = 4;
  localparam int DEF_LANE_W = 9;

  // kind of command held in the address stage
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int AW    = DEF_AW,
  parameter int LANES = DEF_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             go,
  input  logic             wr_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic             s2_wr,
  output logic [AW-1:0]    s2_addr,
  output logic [LANES-1:0] s2_be
);

  logic [LANES-1:0] s1_be;
  op_e              next_op;

  always_comb begin
    if (!go)       next_op = OP_IDLE;
    else if (wr_n) next_op = OP_READ;
    else           next_op = OP_WRITE;
  end

  // stage 1: command latched at the address edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= OP_IDLE;
    end else if (en) begin
      s1_op <= next_op;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_addr <= addr;
      s1_be   <= ~bw_n;
    end
  end

  // stage 2: write waiting for its data on the next enabled edge
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_wr <= 1'b0;
    end else if (en) begin
      s2_wr <= (s1_op == OP_WRITE);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array
  import pipe_sram_pkg::*;
#(
  parameter int AW     = DEF_AW,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    we,
  input  logic [LANES-1:0]        we_lane,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  // one simple dual-port memory per lane, read-old-data behaviour
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en && we && we_lane[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (en && re) begin
        rd_q <= mem[raddr];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/pipe_sram_rdpath.sv
module pipe_sram_rdpath
  import pipe_sram_pkg::*;
#(
  parameter int AW     = DEF_AW,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  op_e                     s1_op,
  input  logic [AW-1:0]           s1_addr,
  input  logic                    s2_wr,
  input  logic [AW-1:0]           s2_addr,
  input  logic [LANES-1:0]        s2_be,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] arr_q,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int WORD_W = LANES * LANE_W;

  logic              rd_vld;
  logic [LANES-1:0]  fwd_sel;
  logic [WORD_W-1:0] fwd_q;
  logic              hit;

  // the write being committed on this edge targets the word being read
  assign hit = (s1_op == OP_READ) && s2_wr && (s2_addr == s1_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
    end else if (en) begin
      rd_vld <= (s1_op == OP_READ);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      fwd_sel <= hit ? s2_be : '0;
      fwd_q   <= wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mux
    assign dq_out[g*LANE_W +: LANE_W] = fwd_sel[g] ? fwd_q[g*LANE_W +: LANE_W]
                                                   : arr_q[g*LANE_W +: LANE_W];
  end

  assign dq_oe = rd_vld && !oe_n;

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW     = DEF_AW,
  parameter int LANES  = DEF_LANES,
  parameter int LANE_W = DEF_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    adv_ld_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [AW-1:0]           addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int WORD_W = LANES * LANE_W;

  logic              en;
  logic              go;
  op_e               s1_op;
  logic [AW-1:0]     s1_addr;
  logic              s2_wr;
  logic [AW-1:0]     s2_addr;
  logic [LANES-1:0]  s2_be;
  logic [WORD_W-1:0] arr_q;

  assign en = !clk_en_n;
  assign go = !cs1_n && cs2 && !cs3_n && !adv_ld_n;

  pipe_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .go      (go),
    .wr_n    (wr_n),
    .bw_n    (bw_n),
    .addr    (addr),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_wr   (s2_wr),
    .s2_addr (s2_addr),
    .s2_be   (s2_be)
  );

  pipe_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .en      (en),
    .we      (s2_wr),
    .we_lane (s2_be),
    .waddr   (s2_addr),
    .wdata   (dq_in),
    .re      (s1_op == OP_READ),
    .raddr   (s1_addr),
    .rdata   (arr_q)
  );

  pipe_sram_rdpath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_rdpath (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s2_wr   (s2_wr),
    .s2_addr (s2_addr),
    .s2_be   (s2_be),
    .wdata   (dq_in),
    .arr_q   (arr_q),
    .oe_n    (oe_n),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              adv_ld_n,
  input logic              wr_n,
  input logic              oe_n,
  input logic [WORD_W-1:0] dq_out,
  input logic              dq_oe
);

  logic cmd;
  assign cmd = !cs1_n && cs2 && !cs3_n && !adv_ld_n;

  assert_rst_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dq_oe);

  assert_read_drive_R2: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && cmd && wr_n) ##1 !clk_en_n |=> (dq_oe == !oe_n));

  assert_oe_off_R3: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  // R9 and R10: an unqualified edge behaves as this deselect
  assert_desel_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !cmd) ##1 !clk_en_n |=> !dq_oe);

  assert_wr_turn_R5: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && cmd && !wr_n) ##1 !clk_en_n |=> !dq_oe);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> $stable(dq_out));

endmodule

bind pipe_sram pipe_sram_chk #(.WORD_W(LANES*LANE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en_n (clk_en_n),
  .cs1_n    (cs1_n),
  .cs2      (cs2),
  .cs3_n    (cs3_n),
  .adv_ld_n (adv_ld_n),
  .wr_n     (wr_n),
  .oe_n     (oe_n),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/tb_pipe_sram.sv
`timescale 1ns/1ps
module tb_pipe_sram;

  localparam int AW = 10;
  localparam int W  = 36;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic          cs1_n = 1'b1;
  logic          cs2 = 1'b0;
  logic          cs3_n = 1'b1;
  logic          adv_ld_n = 1'b0;
  logic          wr_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic [W-1:0]  dq_in = '0;
  logic [W-1:0]  dq_out;
  logic          dq_oe;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [W-1:0] D5   = 36'hA_BCDE_0123;
  localparam logic [W-1:0] D7   = 36'h5_5AA5_C33C;
  localparam logic [W-1:0] D7N  = 36'hF_0F0F_1E1E;
  localparam logic [W-1:0] D9   = 36'h1_2345_6789;
  localparam logic [W-1:0] D9N  = 36'hF_EDCB_A987;
  localparam logic [W-1:0] BAD  = 36'h0_DEAD_BEEF;
  localparam logic [W-1:0] D20  = 36'h3_1415_9265;
  localparam logic [W-1:0] D21  = 36'h2_7182_8182;

  always #10 clk = ~clk;

  pipe_sram dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .adv_ld_n(adv_ld_n), .wr_n(wr_n), .bw_n(bw_n),
    .addr(addr), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_w,
                                         input logic [W-1:0] new_w,
                                         input logic [3:0] sel_n);
    logic [W-1:0] r;
    r = old_w;
    for (int i = 0; i < 4; i++) if (!sel_n[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_raw(input logic c1n, input logic c2, input logic c3n,
                          input logic advn, input logic wrn, input logic [AW-1:0] a,
                          input logic [3:0] bwn, input logic [W-1:0] d);
    @(negedge clk);
    cs1_n = c1n; cs2 = c2; cs3_n = c3n; adv_ld_n = advn;
    wr_n = wrn; addr = a; bw_n = bwn; dq_in = d;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] bwn);
    step_raw(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, a, bwn, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [W-1:0] d);
    step_raw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, a, 4'hF, d);
  endtask

  task automatic ds(input logic [W-1:0] d);
    step_raw(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, 4'hF, d);
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic [W-1:0] d);
    wr(a, 4'h0); ds('0); ds(d);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    check("R1 reset idle", {35'd0, dq_oe}, '0);
  endtask

  task automatic t_read;
    fill(5, D5);
    rd(5, '0);
    check("R2 not yet driven", {35'd0, dq_oe}, '0);
    ds('0);
    check("R2 drive", {35'd0, dq_oe}, 1);
    check("R2 data", dq_out, D5);
    check("R4 still driven after deselect edge", {35'd0, dq_oe}, 1);
    ds('0);
    check("R4 off one edge later", {35'd0, dq_oe}, '0);
  endtask

  task automatic t_oe;
    rd(5, '0); ds('0);
    oe_n = 1'b1; #1;
    check("R3 oe high", {35'd0, dq_oe}, '0);
    oe_n = 1'b0; #1;
    check("R3 oe low", {35'd0, dq_oe}, 1);
    ds('0);
  endtask

  task automatic t_lanes;
    fill(7, D7);
    wr(7, 4'b1010); ds('0); ds(D7N);
    rd(7, '0); ds('0);
    check("R6 lane merge", dq_out, merge(D7, D7N, 4'b1010));
    wr(7, 4'hF); ds('0); ds(BAD);
    rd(7, '0); ds('0);
    check("R6 no lane selected", dq_out, merge(D7, D7N, 4'b1010));
  endtask

  task automatic t_fwd;
    fill(9, D9);
    rd(5, '0);
    wr(9, 4'b0011);
    check("R5 prior read still out", dq_out, D5);
    rd(9, '0);
    check("R5 bus off in turnaround", {35'd0, dq_oe}, '0);
    rd(9, D9N);
    check("R7 forwarded merge", dq_out, merge(D9, D9N, 4'b0011));
    ds('0);
    check("R7 written merge", dq_out, merge(D9, D9N, 4'b0011));
    ds('0);
  endtask

  task automatic t_freeze;
    rd(5, '0);
    clk_en_n = 1'b1;
    wr(5, 4'h0);
    check("R8 frozen no output", {35'd0, dq_oe}, '0);
    ds(BAD); ds(BAD);
    check("R8 still frozen", {35'd0, dq_oe}, '0);
    clk_en_n = 1'b0;
    ds(BAD);
    check("R8 resumed read data", dq_out, D5);
    clk_en_n = 1'b1;
    rd(7, BAD);
    check("R8 output held", dq_out, D5);
    check("R8 drive held", {35'd0, dq_oe}, 1);
    clk_en_n = 1'b0;
    ds('0); ds('0);
    rd(5, '0); ds('0);
    check("R8 frozen write ignored", dq_out, D5);
  endtask

  task automatic t_select;
    step_raw(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5, 4'h0, '0); ds('0); ds(BAD);
    step_raw(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5, 4'h0, '0); ds('0); ds(BAD);
    step_raw(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5, 4'h0, '0); ds('0); ds(BAD);
    rd(5, '0); ds('0);
    check("R9 enables block writes", dq_out, D5);
    step_raw(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5, 4'h0, '0); ds('0); ds(BAD);
    rd(5, '0); ds('0);
    check("R10 adv high blocks write", dq_out, D5);
    rd(5, '0);
    step_raw(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5, 4'hF, '0);
    check("R10 earlier read out", {35'd0, dq_oe}, 1);
    ds('0);
    check("R10 adv high acts as deselect", {35'd0, dq_oe}, '0);
  endtask

  task automatic t_b2b;
    wr(20, 4'h0);
    rd(5, '0);
    step_raw(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 21, 4'h0, D20);
    check("R11 read between writes", dq_out, D5);
    rd(20, '0);
    check("R11 turnaround off", {35'd0, dq_oe}, '0);
    ds(D21);
    check("R11 read after write", dq_out, D20);
    rd(21, '0);
    ds('0);
    check("R11 second write", dq_out, D21);
  endtask

  initial begin
    t_reset;
    t_read;
    t_oe;
    t_lanes;
    t_fwd;
    t_freeze;
    t_select;
    t_b2b;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule